// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block screens received Ethernet frames by their destination address. The six address octets arrive one per accepted cycle on a byte-wide input, first octet first. While they stream in, the block builds the full 48-bit address and runs a CRC32 over it. One clock after the sixth octet it raises a single-cycle result strobe that carries an accept verdict and flags for broadcast and multicast.

The verdict comes from a fixed decision order:

1. Promiscuous mode accepts everything.
2. Broadcast is accepted unless it is disabled.
3. The pass-all-multicast option accepts any group address.
4. Otherwise the frame goes to one of two matchers. The exact matcher compares against the station address, and its result can be inverted. The 64-bin hash matcher looks up a pair of 32-bit tables.

Unicast and multicast frames each have their own hash enable.

The caller owns the receive-all override, FCS checking and frame storage. It keeps the configuration inputs steady while a verdict is being presented.

Top module: `rx_addr_screen`

## Requirements
- R1: After reset `res_valid` is low. It is high for exactly one cycle, the cycle that follows the clock edge that accepts the sixth octet of an address. In every other cycle `res_valid`, `res_accept`, `res_bcast` and `res_mcast` are all low.
- R2: With `cfg_promisc` high, every address is accepted, broadcast included, whatever the other settings are.
- R3: An address of all ones is broadcast. `res_bcast` is set for it, and it is accepted exactly when `cfg_bcast_off` is low. This decision takes precedence over the multicast, hash and exact rules.
- R4: An address is multicast when bit 0 of its first octet is 1 and it is not broadcast. `res_mcast` reports this, and `res_bcast` and `res_mcast` are never set together.
- R5: With `cfg_mcast_all` high, every multicast address is accepted.
- R6: In exact mode an address is accepted when all 48 bits equal `station_addr`. The first octet received is compared with `station_addr[7:0]`, and the sixth with `station_addr[47:40]`.
- R7: In exact mode, `cfg_invert` high inverts the exact-match verdict.
- R8: The hash index is bits 31:26 of a CRC32 register. The register starts at all ones and is updated octet by octet, least significant bit first, with the reflected polynomial 0xEDB88320. No final inversion is applied.
- R9: Bit 5 of the hash index selects `hash_hi` when it is 1 and `hash_lo` when it is 0. Bits 4:0 pick the bit within that register, and that bit is the verdict. An empty table therefore rejects.
- R10: `cfg_hash_uni` puts only unicast addresses in hash mode. `cfg_hash_multi` puts only multicast addresses in hash mode. An address whose hash enable is low uses exact mode.
- R11: Octets count only in cycles where `in_valid` is high, so idle gaps inside an address are allowed. A new address may start in the same cycle that the previous verdict is presented.
- R12: `cfg_invert` has no effect on a hash-mode verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | `in_octet` carries an address octet this cycle |
| in_octet | input | 8 | Address octet, first octet first |
| cfg_promisc | input | 1 | Accept all frames |
| cfg_bcast_off | input | 1 | Reject broadcast |
| cfg_mcast_all | input | 1 | Accept all multicast |
| cfg_hash_uni | input | 1 | Unicast uses hash matching |
| cfg_hash_multi | input | 1 | Multicast uses hash matching |
| cfg_invert | input | 1 | Invert the exact-match verdict |
| station_addr | input | 48 | Station address, first octet in bits 7:0 |
| hash_hi | input | 32 | Hash bins 32..63 |
| hash_lo | input | 32 | Hash bins 0..31 |
| res_valid | output | 1 | One-cycle verdict strobe |
| res_accept | output | 1 | Frame accepted |
| res_bcast | output | 1 | Address is broadcast |
| res_mcast | output | 1 | Address is multicast, not broadcast |

## Verification
Every verdict and flag is due in the single cycle after the rising edge that takes in the sixth octet, and it is gone one cycle later. The bench drives octets on falling edges. It samples at the falling edge that follows the last octet's capture edge, and again one cycle on to confirm that the strobe has dropped. In the back-to-back case, the previous verdict is read at the same falling edge that presents the next address's first octet, before that octet is driven. Hash expectations use a bit-serial CRC model in the bench, so each test can place a single set bit in the bin that matters.

// File: rtl/rxscr_pkg.sv
`timescale 1ns/1ps
// Shared constants and configuration type for the destination address screen.
// Assumes the standard 48-bit Ethernet address carried in 8-bit octets.
package rxscr_pkg;
    localparam int unsigned OCTET_BITS  = 8;
    localparam int unsigned ADDR_OCTETS = 6;
    localparam int unsigned CRC_BITS    = 32;
    localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
    localparam int unsigned HASH_IDX_W  = 6;

    typedef struct packed {
        logic promisc;
        logic bcast_off;
        logic mcast_all;
        logic hash_uni;
        logic hash_multi;
        logic invert;
    } screen_cfg_t;
endpackage

// File: rtl/addr_crc_step.sv
`timescale 1ns/1ps
// One octet of reflected CRC32 update, purely combinational.
// Assumes the data is shifted in LSB first; the stage chain is unrolled by generate.
module addr_crc_step #(
    parameter int unsigned CW         = 32,
    parameter int unsigned DW         = 8,
    parameter logic [CW-1:0] POLY     = 32'hEDB88320
) (
    input  logic [CW-1:0] crc_in,
    input  logic [DW-1:0] data,
    output logic [CW-1:0] crc_out
);
    logic [DW:0][CW-1:0] stage;

    // Fold the octet into the low end of the remainder.
    assign stage[0] = crc_in ^ {{(CW-DW){1'b0}}, data};

    genvar g;
    generate
        for (g = 0; g < DW; g++) begin : g_bit
            // One bit of division by the reflected polynomial.
            assign stage[g+1] = stage[g][0] ? ((stage[g] >> 1) ^ POLY) : (stage[g] >> 1);
        end
    endgenerate

    assign crc_out = stage[DW];
endmodule

// File: rtl/addr_collect.sv
`timescale 1ns/1ps
// Gathers address octets, runs the CRC, and holds the complete address and
// hash index for one verdict cycle. Assumes in_octet is valid only with in_valid.
// A new address may begin in the cycle the held result is presented.
module addr_collect #(
    parameter int unsigned OW    = 8,
    parameter int unsigned NOCT  = 6,
    parameter int unsigned CW    = 32,
    parameter logic [CW-1:0] POLY = 32'hEDB88320,
    parameter int unsigned IDXW  = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [OW-1:0]        in_octet,
    output logic                 done,
    output logic [OW*NOCT-1:0]   addr,
    output logic [IDXW-1:0]      hash_idx
);
    localparam int unsigned AW    = OW * NOCT;
    localparam int unsigned CNT_W = $clog2(NOCT);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NOCT - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [AW-1:0]    build_q;
    logic [AW-1:0]    build_next;
    logic [CW-1:0]    crc_q;
    logic [CW-1:0]    crc_seed;
    logic [CW-1:0]    crc_next;
    logic             last_oct;

    // Restart the remainder at all ones on the first octet of each address.
    assign crc_seed   = (cnt_q == '0) ? '1 : crc_q;
    // New octet enters at the top, so the first octet ends in the low byte.
    assign build_next = {in_octet, build_q[AW-1:OW]};
    assign last_oct   = in_valid && (cnt_q == LAST_CNT);

    addr_crc_step #(.CW(CW), .DW(OW), .POLY(POLY)) u_crc (
        .crc_in  (crc_seed),
        .data    (in_octet),
        .crc_out (crc_next)
    );

    // Octet counter, assembly registers and held result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            build_q  <= '0;
            crc_q    <= '1;
            done     <= 1'b0;
            addr     <= '0;
            hash_idx <= '0;
        end else begin
            done <= last_oct;
            if (in_valid) begin
                cnt_q   <= last_oct ? '0 : cnt_q + 1'b1;
                build_q <= build_next;
                crc_q   <= crc_next;
            end
            if (last_oct) begin
                addr     <= build_next;
                hash_idx <= crc_next[CW-1 -: IDXW];
            end
        end
    end

    assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_CNT);
    assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_after_octet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(in_valid));
endmodule

// File: rtl/addr_verdict.sv
`timescale 1ns/1ps
// Combinational accept decision for a completed address.
// Order: promiscuous, broadcast, pass-all-multicast, then hash or exact match.
// Assumes the configuration is steady while the verdict is used.
module addr_verdict
    import rxscr_pkg::*;
#(
    parameter int unsigned AW   = 48,
    parameter int unsigned IDXW = 6
) (
    input  screen_cfg_t              cfg,
    input  logic [AW-1:0]            station,
    input  logic [2**(IDXW-1)-1:0]   tbl_hi,
    input  logic [2**(IDXW-1)-1:0]   tbl_lo,
    input  logic [AW-1:0]            addr,
    input  logic [IDXW-1:0]          idx,
    output logic                     accept,
    output logic                     is_bcast,
    output logic                     is_mcast
);
    localparam int unsigned BIN_W = IDXW - 1;

    logic group_bit;
    logic use_hash;
    logic hash_hit;
    logic exact_hit;

    // Address class flags.
    assign is_bcast  = &addr;
    assign group_bit = addr[0];
    assign is_mcast  = group_bit && !is_bcast;

    // Matcher selection and the two matcher results.
    assign use_hash  = group_bit ? cfg.hash_multi : cfg.hash_uni;
    assign hash_hit  = idx[IDXW-1] ? tbl_hi[idx[BIN_W-1:0]] : tbl_lo[idx[BIN_W-1:0]];
    assign exact_hit = (addr == station) ^ cfg.invert;

    // Priority chain producing the verdict.
    always_comb begin
        if (cfg.promisc)                     accept = 1'b1;
        else if (is_bcast)                   accept = !cfg.bcast_off;
        else if (group_bit && cfg.mcast_all) accept = 1'b1;
        else if (use_hash)                   accept = hash_hit;
        else                                 accept = exact_hit;
    end
endmodule

// File: rtl/rx_addr_screen.sv
`timescale 1ns/1ps
// Destination address screen: collects six octets and presents a one-cycle
// verdict with broadcast and multicast flags one clock after the sixth octet.
// Assumes configuration inputs are held steady during the verdict cycle.
module rx_addr_screen
    import rxscr_pkg::*;
#(
    parameter int unsigned OCTET_W      = OCTET_BITS,
    parameter int unsigned NUM_OCTETS   = ADDR_OCTETS,
    parameter int unsigned CRC_W        = CRC_BITS,
    parameter logic [CRC_W-1:0] POLY    = CRC_POLY,
    parameter int unsigned IDX_W        = HASH_IDX_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  logic [OCTET_W-1:0]                in_octet,
    input  logic                              cfg_promisc,
    input  logic                              cfg_bcast_off,
    input  logic                              cfg_mcast_all,
    input  logic                              cfg_hash_uni,
    input  logic                              cfg_hash_multi,
    input  logic                              cfg_invert,
    input  logic [OCTET_W*NUM_OCTETS-1:0]     station_addr,
    input  logic [2**(IDX_W-1)-1:0]           hash_hi,
    input  logic [2**(IDX_W-1)-1:0]           hash_lo,
    output logic                              res_valid,
    output logic                              res_accept,
    output logic                              res_bcast,
    output logic                              res_mcast
);
    localparam int unsigned AW = OCTET_W * NUM_OCTETS;

    screen_cfg_t     cfg;
    logic            done;
    logic [AW-1:0]   held_addr;
    logic [IDX_W-1:0] held_idx;
    logic            v_accept;
    logic            v_bcast;
    logic            v_mcast;

    // Pack the configuration pins into the shared type.
    assign cfg = '{promisc: cfg_promisc, bcast_off: cfg_bcast_off, mcast_all: cfg_mcast_all,
                   hash_uni: cfg_hash_uni, hash_multi: cfg_hash_multi, invert: cfg_invert};

    addr_collect #(.OW(OCTET_W), .NOCT(NUM_OCTETS), .CW(CRC_W), .POLY(POLY), .IDXW(IDX_W)) u_collect (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_octet (in_octet),
        .done     (done),
        .addr     (held_addr),
        .hash_idx (held_idx)
    );

    addr_verdict #(.AW(AW), .IDXW(IDX_W)) u_verdict (
        .cfg      (cfg),
        .station  (station_addr),
        .tbl_hi   (hash_hi),
        .tbl_lo   (hash_lo),
        .addr     (held_addr),
        .idx      (held_idx),
        .accept   (v_accept),
        .is_bcast (v_bcast),
        .is_mcast (v_mcast)
    );

    // Outputs are qualified by the verdict strobe.
    assign res_valid  = done;
    assign res_accept = done && v_accept;
    assign res_bcast  = done && v_bcast;
    assign res_mcast  = done && v_mcast;

    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(res_accept || res_bcast || res_mcast));
    assert_promisc_accepts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && cfg_promisc) |-> res_accept);
    assert_bcast_rule_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !cfg_promisc && res_bcast) |-> (res_accept == !cfg_bcast_off));
    assert_class_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_bcast, res_mcast}));
    assert_mcast_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !cfg_promisc && res_mcast && cfg_mcast_all) |-> res_accept);
    assert_empty_table_rejects_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !cfg_promisc && !res_bcast && !(res_mcast && cfg_mcast_all)
         && (res_mcast ? cfg_hash_multi : cfg_hash_uni)
         && (hash_hi == '0) && (hash_lo == '0)) |-> !res_accept);
endmodule

// File: tb/sim_rx_addr_screen.sv
`timescale 1ns/1ps
// Directed bench for rx_addr_screen: one task per scenario, each checking itself.
module sim_rx_addr_screen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_octet = '0;
    logic        cfg_promisc = 1'b0, cfg_bcast_off = 1'b0, cfg_mcast_all = 1'b0;
    logic        cfg_hash_uni = 1'b0, cfg_hash_multi = 1'b0, cfg_invert = 1'b0;
    logic [47:0] station_addr = '0;
    logic [31:0] hash_hi = '0, hash_lo = '0;
    logic        res_valid, res_accept, res_bcast, res_mcast;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    rx_addr_screen u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_octet(in_octet),
        .cfg_promisc(cfg_promisc), .cfg_bcast_off(cfg_bcast_off), .cfg_mcast_all(cfg_mcast_all),
        .cfg_hash_uni(cfg_hash_uni), .cfg_hash_multi(cfg_hash_multi), .cfg_invert(cfg_invert),
        .station_addr(station_addr), .hash_hi(hash_hi), .hash_lo(hash_lo),
        .res_valid(res_valid), .res_accept(res_accept), .res_bcast(res_bcast), .res_mcast(res_mcast)
    );

    // Build an address value whose first octet sits in bits 7:0.
    function automatic logic [47:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
        return {b5, b4, b3, b2, b1, b0};
    endfunction

    // Bit-serial CRC model: start all ones, LSB first, reflected polynomial.
    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int b = 0; b < 6; b++) begin
            for (int j = 0; j < 8; j++) begin
                logic fb = c[0] ^ a[8*b+j];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return c[31:26];
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_octet(input logic [7:0] b);
        @(negedge clk); in_valid = 1'b1; in_octet = b;
    endtask

    task automatic idle();
        @(negedge clk); in_valid = 1'b0; in_octet = 8'h00;
    endtask

    task automatic push_addr(input logic [47:0] a);
        for (int i = 0; i < 6; i++) send_octet(a[8*i +: 8]);
    endtask

    // Sends an address, checks the verdict cycle and that the strobe then drops.
    task automatic expect_verdict(input string req, input logic [47:0] a, input logic exp_acc);
        logic eb = &a;
        logic em = a[0] & ~eb;
        push_addr(a);
        idle();
        check(req, "valid", res_valid, 1);
        check(req, "accept", res_accept, exp_acc);
        check(req, "bcast", res_bcast, eb);
        check(req, "mcast", res_mcast, em);
        idle();
        check("R1", "strobe drops", res_valid, 0);
    endtask

    task automatic clear_cfg();
        cfg_promisc = 0; cfg_bcast_off = 0; cfg_mcast_all = 0;
        cfg_hash_uni = 0; cfg_hash_multi = 0; cfg_invert = 0;
        hash_hi = '0; hash_lo = '0;
        station_addr = mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
    endtask

    task automatic t_reset();
        check("R1", "reset valid", res_valid, 0);
        check("R1", "reset accept", res_accept, 0);
    endtask

    task automatic t_promisc();
        clear_cfg(); cfg_promisc = 1; cfg_bcast_off = 1;
        expect_verdict("R2", mk(8'h06, 8'h99, 8'h88, 8'h77, 8'h66, 8'h55), 1);
        expect_verdict("R2", 48'hFFFF_FFFF_FFFF, 1);
    endtask

    task automatic t_bcast();
        clear_cfg();
        expect_verdict("R3", 48'hFFFF_FFFF_FFFF, 1);
        cfg_bcast_off = 1; cfg_mcast_all = 1;
        expect_verdict("R3", 48'hFFFF_FFFF_FFFF, 0);
    endtask

    task automatic t_mcast_all();
        clear_cfg(); cfg_mcast_all = 1;
        expect_verdict("R5", mk(8'h01, 8'h00, 8'h5E, 8'h10, 8'h20, 8'h30), 1);
        cfg_mcast_all = 0;
        expect_verdict("R4", mk(8'h01, 8'h00, 8'h5E, 8'h10, 8'h20, 8'h30), 0);
    endtask

    task automatic t_exact();
        clear_cfg();
        expect_verdict("R6", station_addr, 1);
        expect_verdict("R6", mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h54), 0);
        station_addr = mk(8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'h01);
        expect_verdict("R6", station_addr, 1);
    endtask

    task automatic t_invert();
        clear_cfg(); cfg_invert = 1;
        expect_verdict("R7", station_addr, 0);
        expect_verdict("R7", mk(8'h0A, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 1);
    endtask

    task automatic t_hash_one(input logic [47:0] a);
        logic [5:0] ix = ref_idx(a);
        logic [31:0] one = 32'h1 << ix[4:0];
        hash_hi = ix[5] ? one : '0; hash_lo = ix[5] ? '0 : one;
        expect_verdict("R8", a, 1);
        hash_hi = ix[5] ? '0 : one; hash_lo = ix[5] ? one : '0;
        expect_verdict("R9", a, 0);
        hash_hi = ix[5] ? ~one : '1; hash_lo = ix[5] ? '1 : ~one;
        expect_verdict("R9", a, 0);
    endtask

    task automatic t_hash();
        clear_cfg(); cfg_hash_uni = 1; cfg_hash_multi = 1;
        t_hash_one(mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55));
        t_hash_one(mk(8'h01, 8'h00, 8'h5E, 8'h7F, 8'h00, 8'h01));
        t_hash_one(mk(8'hA4, 8'h5B, 8'hC0, 8'h12, 8'hEE, 8'h09));
        cfg_invert = 1; hash_hi = '0; hash_lo = '0;
        expect_verdict("R12", station_addr, 0);
        hash_hi = '1; hash_lo = '1;
        expect_verdict("R12", mk(8'h0C, 8'h1, 8'h2, 8'h3, 8'h4, 8'h5), 1);
    endtask

    task automatic t_split();
        clear_cfg(); cfg_hash_uni = 1;
        expect_verdict("R10", station_addr, 0);
        station_addr = mk(8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h0E);
        expect_verdict("R10", station_addr, 1);
        cfg_hash_uni = 0; cfg_hash_multi = 1;
        expect_verdict("R10", station_addr, 0);
        station_addr = mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
        expect_verdict("R10", station_addr, 1);
    endtask

    task automatic t_back_to_back();
        logic [47:0] a = station_addr;
        logic [47:0] b = mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h56);
        clear_cfg();
        push_addr(a);
        // Verdict of a is present here; sample before driving b's first octet.
        @(negedge clk);
        check("R11", "first valid", res_valid, 1);
        check("R11", "first accept", res_accept, 1);
        in_valid = 1; in_octet = b[7:0];
        send_octet(b[15:8]);
        check("R11", "no early strobe", res_valid, 0);
        send_octet(b[23:16]);
        idle(); idle();
        check("R11", "gap no strobe", res_valid, 0);
        send_octet(b[31:24]); send_octet(b[39:32]); send_octet(b[47:40]);
        idle();
        check("R11", "second valid", res_valid, 1);
        check("R11", "second accept", res_accept, 0);
        idle();
        check("R1", "strobe drops", res_valid, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        clear_cfg();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_promisc();
        t_bcast();
        t_mcast_all();
        t_exact();
        t_invert();
        t_hash();
        t_split();
        t_back_to_back();
        finish_run();
    end
endmodule